// File: doc/BRIEF.md
# Byte Serializer with Self-Aligning Byte Timer

This block turns a stream of parallel bytes into a serial bit stream that runs at eight times the byte rate, all in one fast bit-clock domain. A byte-rate strobe from outside marks when the parallel inputs are valid. The phase of that strobe against the bit clock is unknown. The strobe captures each byte into an input register. An internal byte timer, a divide-by-eight count of the bit clock, moves the captured byte into a buffer and starts shifting out the previous one. The most significant input bit leaves first.

Because the strobe phase is arbitrary, a phase monitor checks whether the strobe lands too close to the internal transfer point. If it does, the monitor raises a sticky error flag. A rising edge on the sync input shifts the internal byte timer by half a byte, which moves the transfer point away from the strobe. One byte is lost from the serial stream during that switch. A second divide-by-eight counter runs freely and is never adjusted. Its output can serve as the system reference from which the external byte strobe is generated.

Top module: `byte_serializer`

## Requirements
- R1: While reset is high, both byte counters hold 0. While reset is high and in the first cycle after it, ser_out, ibyte_clk, ref_clk and phase_err are all 0.
- R2: par_data is captured only at the end of a cycle in which byte_stb is high. Values present in other cycles never reach the serial stream.
- R3: A transfer happens at the end of each cycle in which the internal count is 7. At that point the shifter loads the buffer and the buffer loads the input register. The shifter then sends par_data[7] first and par_data[0] last, one bit per cycle. Before any adjustment, a byte strobed in cycle c appears in the frame that starts in cycle 8*(c/8)+16, where c is counted from the first cycle after reset and c mod 8 lies in 0..6. If c mod 8 is 7, the byte appears one frame later.
- R4: ibyte_clk is high while the internal count is 4..7. Each serial frame begins in the cycle after ibyte_clk falls.
- R5: ref_clk is high exactly when (cycles since reset) mod 8 is 4..7. A sync edge never changes it.
- R6: phase_err goes high in the cycle after a strobe that arrives while the internal count is 6, 7 or 0. A strobe at any other count leaves the flag unchanged.
- R7: Once set, phase_err stays high until a phase adjustment or a reset.
- R8: A rising edge of sync_in arms an adjustment. The adjustment takes effect at the first transfer at or after that edge. It reloads the internal count with 4 instead of 0, which shortens that byte to four bit periods, and it clears phase_err. From then on ibyte_clk is the inverse of ref_clk. Holding sync_in high causes no further adjustment.
- R9: Across one adjustment, the serial frames keep the input order. Exactly one input byte is missing, and at most one byte is repeated.
- R10: After an adjustment, a strobe at a fixed phase is checked against the shifted window. Strobe phases 6, 7 and 0 no longer flag, and phases 2, 3 and 4 do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | DATA_W | Parallel byte, bit DATA_W-1 sent first |
| byte_stb | input | 1 | External byte strobe, one cycle per byte |
| sync_in | input | 1 | Rising edge requests a half-byte timer slip |
| ser_out | output | 1 | Serial data |
| ibyte_clk | output | 1 | Internal byte timer, phase adjustable |
| ref_clk | output | 1 | Free-running divide-by-DATA_W reference |
| phase_err | output | 1 | Sticky strobe/transfer conflict flag |

## Verification
A captured byte reaches the serial output two byte periods after the byte period in which it was strobed. If it was strobed in the transfer slot itself, it arrives three byte periods later. phase_err follows an offending strobe by one cycle. An adjustment lands on the first transfer at or after the sync edge, and the flag reads low in the very next cycle. The bench samples every output at the falling clock edge. It rebuilds each frame starting from the observed falling edge of ibyte_clk, so every comparison is made against the frame or cycle in which the requirement says the result must be present.

// File: rtl/bs_pkg.sv
package bs_pkg;

  // State of the sync-request logic that waits for the next transfer point.
  typedef enum logic [0:0] {
    ALIGN_IDLE  = 1'b0,
    ALIGN_ARMED = 1'b1
  } align_state_e;

  localparam int DEF_DATA_W = 8;
  localparam int DEF_GUARD  = 1;

endpackage

// File: rtl/bs_divider.sv
// Wrapping byte counter; optional synchronous reload used for phase slips.
module bs_divider #(
  parameter int RATIO = 8,
  parameter int CNT_W = $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (load_en) begin
      cnt_o <= load_val;
    end else if (cnt_o == LAST) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/bs_phase_mon.sv
// Flags a strobe that falls inside the guard band around the transfer edge.
module bs_phase_mon #(
  parameter int RATIO = 8,
  parameter int GUARD = 1,
  parameter int CNT_W = $clog2(RATIO)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             stb,
  input  logic             clear,
  output logic             err_o
);

  localparam int LAST = RATIO - 1;

  logic in_window;

  generate
    if (GUARD == 0) begin : g_edge_only
      assign in_window = (cnt == CNT_W'(LAST));
    end else begin : g_guard_band
      assign in_window = (int'(cnt) >= (LAST - GUARD)) || (int'(cnt) < GUARD);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o <= 1'b0;
    end else if (clear) begin
      err_o <= 1'b0;
    end else if (stb && in_window) begin
      err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/bs_datapath.sv
// Input register, buffer stage and MSB-first shifter.
module bs_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              stb,
  input  logic              xfer,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] buf_q,
  output logic              ser_o
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
    end else if (stb) begin
      in_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      sh_q  <= '0;
    end else if (xfer) begin
      buf_q <= in_q;
      sh_q  <= buf_q;
    end else begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign ser_o = sh_q[DATA_W-1];

endmodule

// File: rtl/byte_serializer.sv
module byte_serializer
  import bs_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int GUARD  = DEF_GUARD,
  parameter int SLIP   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] par_data,
  input  logic              byte_stb,
  input  logic              sync_in,
  output logic              ser_out,
  output logic              ibyte_clk,
  output logic              ref_clk,
  output logic              phase_err
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SLIP_CNT = CNT_W'(SLIP);

  logic [CNT_W-1:0]  r_cnt;
  logic [CNT_W-1:0]  i_cnt;
  logic              i_term;
  logic              sync_q;
  logic              sync_rise;
  logic              adjust;
  align_state_e      align_st;
  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] buf_q;

  // Reference divider: never reloaded.
  bs_divider #(.RATIO(DATA_W), .CNT_W(CNT_W)) u_ref_div (
    .clk      (clk),
    .rst      (rst),
    .load_en  (1'b0),
    .load_val ({CNT_W{1'b0}}),
    .cnt_o    (r_cnt)
  );

  // Internal byte timer: reloaded with the slip value on an adjustment.
  bs_divider #(.RATIO(DATA_W), .CNT_W(CNT_W)) u_int_div (
    .clk      (clk),
    .rst      (rst),
    .load_en  (adjust),
    .load_val (SLIP_CNT),
    .cnt_o    (i_cnt)
  );

  assign i_term = (i_cnt == LAST);

  // Sync edge detection and arming until the next transfer edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
    end
  end

  assign sync_rise = sync_in & ~sync_q;
  assign adjust    = i_term & (sync_rise | (align_st == ALIGN_ARMED));

  always_ff @(posedge clk) begin
    if (rst) begin
      align_st <= ALIGN_IDLE;
    end else if (adjust) begin
      align_st <= ALIGN_IDLE;
    end else if (sync_rise) begin
      align_st <= ALIGN_ARMED;
    end
  end

  bs_phase_mon #(.RATIO(DATA_W), .GUARD(GUARD), .CNT_W(CNT_W)) u_mon (
    .clk   (clk),
    .rst   (rst),
    .cnt   (i_cnt),
    .stb   (byte_stb),
    .clear (adjust),
    .err_o (phase_err)
  );

  bs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .din   (par_data),
    .stb   (byte_stb),
    .xfer  (i_term),
    .in_q  (in_q),
    .buf_q (buf_q),
    .ser_o (ser_out)
  );

  assign ibyte_clk = i_cnt[CNT_W-1];
  assign ref_clk   = r_cnt[CNT_W-1];

endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int DATA_W = 8,
  parameter int SLIP   = 4,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_stb,
  input logic [DATA_W-1:0] par_data,
  input logic              ser_out,
  input logic [CNT_W-1:0]  ref_cnt,
  input logic [CNT_W-1:0]  int_cnt,
  input logic              xfer,
  input logic              adjust,
  input logic [DATA_W-1:0] in_q,
  input logic [DATA_W-1:0] buf_q,
  input logic              phase_err
);

  logic [CNT_W-1:0] skew;
  assign skew = int_cnt - ref_cnt;

  AST_STB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> (in_q == $past(par_data)));                          // R2

  AST_SER_LOAD: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (ser_out == $past(buf_q[DATA_W-1])));                    // R3

  AST_REF_UNMOVED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adjust)) |-> (skew == $past(skew)));       // R5

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_err) |-> $past(byte_stb));                            // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_err && !adjust) |=> phase_err);                            // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    adjust |=> !phase_err);                                           // R8

  AST_SLIP_LOAD: assert property (@(posedge clk) disable iff (rst)
    adjust |=> (int_cnt == CNT_W'(SLIP)));                            // R8

endmodule

bind byte_serializer bs_checker #(.DATA_W(DATA_W), .SLIP(SLIP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .byte_stb  (byte_stb),
  .par_data  (par_data),
  .ser_out   (ser_out),
  .ref_cnt   (r_cnt),
  .int_cnt   (i_cnt),
  .xfer      (i_term),
  .adjust    (adjust),
  .in_q      (in_q),
  .buf_q     (buf_q),
  .phase_err (phase_err)
);

// File: tb/byte_serializer_test.sv
module byte_serializer_test;

  localparam int NCYC = 480;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] par_data = '0;
  logic       byte_stb = 1'b0;
  logic       sync_in = 1'b0;
  logic       ser_out;
  logic       ibyte_clk;
  logic       ref_clk;
  logic       phase_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] sent [0:63];
  logic [7:0] fval [0:63];
  int         fstart [0:63];
  int         nfr;

  always #4 clk = ~clk;

  byte_serializer uut (
    .clk       (clk),
    .rst       (rst),
    .par_data  (par_data),
    .byte_stb  (byte_stb),
    .sync_in   (sync_in),
    .ser_out   (ser_out),
    .ibyte_clk (ibyte_clk),
    .ref_clk   (ref_clk),
    .phase_err (phase_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; byte_stb = 1'b0; sync_in = 1'b0; par_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Strobe at a fixed phase p, random sync time, frame-level stream check.
  task automatic run_phase(input int p);
    int sync_c, bitn, cur_start, a, prev, idx, step, back, rep, missing, npost, odd;
    logic [7:0] base, acc, v;
    bit prev_ib, in_frame, pre_bad, post_bad;
    base    = 8'($urandom);
    sync_c  = 60 + int'($urandom % 241);
    pre_bad = (p == 6) || (p == 7) || (p == 0);
    post_bad = (p == 2) || (p == 3) || (p == 4);
    do_reset();
    nfr = 0; in_frame = 0; prev_ib = 0; bitn = 0; acc = '0; cur_start = 0;
    for (int c = 0; c < NCYC; c++) begin
      if (c == 0) begin
        check(!ser_out && !ibyte_clk && !ref_clk && !phase_err, "R1", "reset outputs",
              int'({ser_out, ibyte_clk, ref_clk, phase_err}), 0);
      end
      if (ref_clk != ((c % 8) >= 4))
        check(0, "R5", "ref_clk phase", int'(ref_clk), int'((c % 8) >= 4));
      else
        checks++;
      if (prev_ib && !ibyte_clk) begin
        in_frame = 1; bitn = 0; acc = '0; cur_start = c;
      end
      if (in_frame) begin
        acc = {acc[6:0], ser_out};
        bitn++;
        if (bitn == 8) begin
          if (nfr < 64) begin
            fval[nfr] = acc; fstart[nfr] = cur_start; nfr++;
          end
          in_frame = 0;
        end
      end
      prev_ib = ibyte_clk;
      if (c == sync_c - 1) begin
        check(phase_err == pre_bad, "R6", "flag before sync", int'(phase_err), int'(pre_bad));
        check(ibyte_clk == ref_clk, "R4", "timers aligned before sync",
              int'(ibyte_clk), int'(ref_clk));
      end
      if (c == NCYC - 1) begin
        check(phase_err == post_bad, "R10", "flag after slip", int'(phase_err), int'(post_bad));
        check(ibyte_clk == !ref_clk, "R8", "timer slipped by half", int'(ibyte_clk),
              int'(!ref_clk));
      end
      byte_stb = ((c % 8) == p);
      if (byte_stb) begin
        v = base + 8'(((c / 8) * 73) & 255);
        sent[c / 8] = v;
        par_data = v;
      end else begin
        par_data = 8'($urandom);
      end
      sync_in = (c >= sync_c);
      @(negedge clk);
    end
    byte_stb = 1'b0;
    a = -1; prev = -1; back = 0; rep = 0; missing = 0; npost = 0; odd = 0;
    for (int f = 0; f < nfr; f++) begin
      if ((fstart[f] % 8) == 0) begin
        idx = fstart[f] / 8 - 2 - ((p == 7) ? 1 : 0);
        if (idx >= 0) begin
          check(fval[f] == sent[idx], "R3", "frame before slip", int'(fval[f]),
                int'(sent[idx]));
          a = idx;
        end
      end else if ((fstart[f] % 8) == 4) begin
        if (npost == 0) prev = a;
        idx = -1;
        for (int j = 0; j < NCYC / 8; j++) if (sent[j] == fval[f]) idx = j;
        check(idx >= 0, "R9", "frame after slip is an input byte", int'(fval[f]), 0);
        if (idx >= 0) begin
          step = idx - prev;
          if (step < 0) back++;
          else if (step == 0) rep++;
          else missing += step - 1;
          prev = idx;
        end
        npost++;
      end else begin
        odd++;
      end
    end
    check(odd == 0, "R4", "frame starts on byte grid", odd, 0);
    check(npost >= 5, "R8", "frames after slip", npost, 5);
    check(back == 0, "R9", "order kept", back, 0);
    check(rep <= 1, "R9", "repeated bytes", rep, 1);
    check(missing == 1, "R9", "lost bytes", missing, 1);
  endtask

  // Single offending strobe: sticky flag, clear on slip, directed latency.
  task automatic run_sticky();
    logic [7:0] acc;
    do_reset();
    acc = '0;
    for (int c = 0; c < 60; c++) begin
      if (c == 7)  check(phase_err == 1'b1, "R6", "flag after strobe at count 6",
                         int'(phase_err), 1);
      if (c == 40) check(phase_err == 1'b1, "R7", "flag held", int'(phase_err), 1);
      if (c == 47) check(phase_err == 1'b1, "R7", "flag held until slip", int'(phase_err), 1);
      if (c == 48) begin
        check(phase_err == 1'b0, "R8", "flag cleared by slip", int'(phase_err), 0);
        check(ibyte_clk == 1'b1 && ref_clk == 1'b0, "R8", "slip lands at transfer",
              int'({ibyte_clk, ref_clk}), 2);
      end
      if (c >= 16 && c <= 23) acc = {acc[6:0], ser_out};
      if (c == 24) check(acc == 8'hA5, "R3", "first byte latency and bit order",
                         int'(acc), 8'hA5);
      byte_stb = (c == 6);
      par_data = (c == 6) ? 8'hA5 : 8'h5A;
      sync_in  = (c >= 41);
      @(negedge clk);
    end
    byte_stb = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    run_sticky();
    for (int p = 0; p < 8; p++) run_phase(p);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule